// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block turns a single write-only command word into a control action aimed at one processor in a multi-processor system. Software writes the word. The block picks out the action type, the target processor and a vector, and checks the target against the number of processors present. It then raises exactly one per-processor strobe for one clock. There are four actions: post an interrupt vector, reset-and-start, halt, and resume. How each processor responds to its strobe is decided outside this block.

A reset is only honoured when it carries the power-on-reset code. A reset with any other code is dropped and reported on a one-cycle error output. Commands aimed at a processor that is not present are dropped silently. The block also keeps a per-processor "parked" bit. Halt sets it. Reset and resume clear it. A posted interrupt never clears it, so a halted processor is not woken by interrupts.

Top module: `ipi_dispatcher`

## Requirements
- R1: After reset all strobe vectors, `parked`, `err_bad_reset`, `out_cpu` and `out_vec` are zero.
- R2: The command word is decoded as action type in bits [17:16], target processor in bits [12:8] and vector in bits [5:0]. All other bits have no effect.
- R3: An accepted type 0 command raises `int_post[target]` in the cycle after the write, for one cycle. In that cycle `out_cpu` equals the target and `out_vec` equals the vector.
- R4: A type 1 command whose vector equals 6'h01 raises `cpu_reset[target]` in the cycle after the write, for one cycle. It also clears `parked[target]`. `out_vec` reads 0.
- R5: A type 1 command to a present processor whose vector is not 6'h01 raises no strobe. It leaves `parked`, `out_cpu` and `out_vec` unchanged, and pulses `err_bad_reset` for one cycle.
- R6: An accepted type 2 command raises `cpu_halt[target]` for one cycle and sets `parked[target]`.
- R7: An accepted type 3 command raises `cpu_resume[target]` for one cycle and clears `parked[target]`.
- R8: A command whose target is greater than or equal to `cpu_count` (or to MAX_CPUS) raises no strobe and no error. It leaves `parked`, `out_cpu` and `out_vec` unchanged.
- R9: In any cycle at most one bit is set across all four strobe vectors together.
- R10: A posted interrupt leaves `parked` unchanged. A halted processor stays parked when an interrupt is posted to it.
- R11: In a cycle that follows a cycle without `cmd_we`, all strobes and `err_bad_reset` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command write enable, one word per cycle |
| cmd_word | input | 32 | Command word |
| cpu_count | input | 6 | Number of processors present |
| int_post | output | MAX_CPUS | Interrupt-post strobe per processor |
| cpu_reset | output | MAX_CPUS | Reset-and-start strobe per processor |
| cpu_halt | output | MAX_CPUS | Halt strobe per processor |
| cpu_resume | output | MAX_CPUS | Resume strobe per processor |
| out_cpu | output | 5 | Target of the last accepted command |
| out_vec | output | 6 | Vector of the last accepted command (0 unless type 0) |
| err_bad_reset | output | 1 | One-cycle pulse on a rejected reset |
| parked | output | MAX_CPUS | Per-processor halted state |

## Verification
The hardest case to reach is the interaction between the parked state and later commands. An interrupt must reach a processor that is already halted, and a bad-code reset must hit a halted processor that is in range. Neither case may release the processor, which only happens once resume or a valid reset arrives. Random stimulus draws targets from a small window near the top of a varying processor count, which makes repeat hits on the same few processors frequent. Directed sequences then park processor 31 and try interrupt, bad reset and out-of-range commands on it before releasing it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CMD_W    = 32;
  localparam int TYPE_LO  = 16;
  localparam int CPU_LO   = 8;
  localparam int CPU_FW   = 5;
  localparam int VEC_LO   = 0;
  localparam int VEC_W    = 6;
  localparam logic [VEC_W-1:0] POR_CODE = 6'h01;

  typedef enum logic [1:0] {
    ACT_POST   = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_HALT   = 2'd2,
    ACT_RESUME = 2'd3
  } act_e;

  typedef struct packed {
    act_e              act;
    logic [CPU_FW-1:0] tgt;
    logic [VEC_W-1:0]  vec;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.act = act_e'(w[TYPE_LO +: 2]);
    c.tgt = w[CPU_LO +: CPU_FW];
    c.vec = w[VEC_LO +: VEC_W];
    return c;
  endfunction

  function automatic logic tgt_present(input logic [CPU_FW-1:0] tgt,
                                       input int unsigned count,
                                       input int unsigned max_cpus);
    return (int'(tgt) < int'(count)) && (int'(tgt) < int'(max_cpus));
  endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32,
  parameter int CNT_W    = $clog2(MAX_CPUS + 1)
) (
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [CNT_W-1:0]  cpu_count,
  output logic              fire,
  output act_e              act,
  output logic [CPU_FW-1:0] tgt,
  output logic [VEC_W-1:0]  vec,
  output logic              bad_reset
);
  cmd_t c;
  logic in_range;
  logic code_ok;

  always_comb begin
    c        = unpack_cmd(cmd_word);
    act      = c.act;
    tgt      = c.tgt;
    vec      = c.vec;
    in_range = tgt_present(c.tgt, int'(cpu_count), MAX_CPUS);
    code_ok  = (c.act != ACT_RESET) || (c.vec == POR_CODE);
    fire     = cmd_we && in_range && code_ok;
    bad_reset = cmd_we && in_range && !code_ok;
  end
endmodule

// File: rtl/ipi_strobe_gen.sv
module ipi_strobe_gen
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  act_e                act,
  input  logic [CPU_FW-1:0]   tgt,
  input  logic [VEC_W-1:0]    vec,
  input  logic                bad_reset,
  output logic [MAX_CPUS-1:0] int_post,
  output logic [MAX_CPUS-1:0] cpu_reset,
  output logic [MAX_CPUS-1:0] cpu_halt,
  output logic [MAX_CPUS-1:0] cpu_resume,
  output logic [CPU_FW-1:0]   out_cpu,
  output logic [VEC_W-1:0]    out_vec,
  output logic                err_bad_reset
);
  for (genvar i = 0; i < MAX_CPUS; i++) begin : g_cpu
    logic hit;
    assign hit = fire && (tgt == CPU_FW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        int_post[i]   <= 1'b0;
        cpu_reset[i]  <= 1'b0;
        cpu_halt[i]   <= 1'b0;
        cpu_resume[i] <= 1'b0;
      end else begin
        int_post[i]   <= hit && (act == ACT_POST);
        cpu_reset[i]  <= hit && (act == ACT_RESET);
        cpu_halt[i]   <= hit && (act == ACT_HALT);
        cpu_resume[i] <= hit && (act == ACT_RESUME);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cpu       <= '0;
      out_vec       <= '0;
      err_bad_reset <= 1'b0;
    end else begin
      err_bad_reset <= bad_reset;
      if (fire) begin
        out_cpu <= tgt;
        out_vec <= (act == ACT_POST) ? vec : '0;
      end
    end
  end
endmodule

// File: rtl/ipi_park_track.sv
module ipi_park_track
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  act_e                act,
  input  logic [CPU_FW-1:0]   tgt,
  output logic [MAX_CPUS-1:0] parked
);
  for (genvar i = 0; i < MAX_CPUS; i++) begin : g_park
    logic hit;
    assign hit = fire && (tgt == CPU_FW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        parked[i] <= 1'b0;
      end else if (hit) begin
        unique case (act)
          ACT_HALT:              parked[i] <= 1'b1;
          ACT_RESET, ACT_RESUME: parked[i] <= 1'b0;
          default:               parked[i] <= parked[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/ipi_dispatcher.sv
module ipi_dispatcher
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32,
  parameter int CNT_W    = $clog2(MAX_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_we,
  input  logic [CMD_W-1:0]    cmd_word,
  input  logic [CNT_W-1:0]    cpu_count,
  output logic [MAX_CPUS-1:0] int_post,
  output logic [MAX_CPUS-1:0] cpu_reset,
  output logic [MAX_CPUS-1:0] cpu_halt,
  output logic [MAX_CPUS-1:0] cpu_resume,
  output logic [CPU_FW-1:0]   out_cpu,
  output logic [VEC_W-1:0]    out_vec,
  output logic                err_bad_reset,
  output logic [MAX_CPUS-1:0] parked
);
  logic              cmd_fire;
  act_e              cmd_act;
  logic [CPU_FW-1:0] cmd_tgt;
  logic [VEC_W-1:0]  cmd_vec;
  logic              cmd_bad_reset;

  ipi_decode #(.MAX_CPUS(MAX_CPUS), .CNT_W(CNT_W)) u_decode (
    .cmd_we    (cmd_we),
    .cmd_word  (cmd_word),
    .cpu_count (cpu_count),
    .fire      (cmd_fire),
    .act       (cmd_act),
    .tgt       (cmd_tgt),
    .vec       (cmd_vec),
    .bad_reset (cmd_bad_reset)
  );

  ipi_strobe_gen #(.MAX_CPUS(MAX_CPUS)) u_strobe (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (cmd_fire),
    .act           (cmd_act),
    .tgt           (cmd_tgt),
    .vec           (cmd_vec),
    .bad_reset     (cmd_bad_reset),
    .int_post      (int_post),
    .cpu_reset     (cpu_reset),
    .cpu_halt      (cpu_halt),
    .cpu_resume    (cpu_resume),
    .out_cpu       (out_cpu),
    .out_vec       (out_vec),
    .err_bad_reset (err_bad_reset)
  );

  ipi_park_track #(.MAX_CPUS(MAX_CPUS)) u_park (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (cmd_fire),
    .act    (cmd_act),
    .tgt    (cmd_tgt),
    .parked (parked)
  );
endmodule

// File: rtl/ipi_dispatcher_chk.sv
module ipi_dispatcher_chk #(
  parameter int MAX_CPUS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_we,
  input logic                cmd_fire,
  input logic                cmd_bad_reset,
  input logic [MAX_CPUS-1:0] int_post,
  input logic [MAX_CPUS-1:0] cpu_reset,
  input logic [MAX_CPUS-1:0] cpu_halt,
  input logic [MAX_CPUS-1:0] cpu_resume,
  input logic                err_bad_reset,
  input logic [MAX_CPUS-1:0] parked
);
  logic any_strobe;
  assign any_strobe = |{int_post, cpu_reset, cpu_halt, cpu_resume};

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_post, cpu_reset, cpu_halt, cpu_resume}));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> (!any_strobe && !err_bad_reset));

  p_fire_or_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_fire && cmd_bad_reset));

  p_err_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_reset |-> !any_strobe);

  p_halt_parks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_halt) |-> ((parked & cpu_halt) == cpu_halt));

  p_resume_unparks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_resume) |-> ((parked & cpu_resume) == '0));

  p_reset_unparks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_reset) |-> ((parked & cpu_reset) == '0));

  p_post_keeps_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_post) |-> $stable(parked));

  p_err_keeps_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_bad_reset |-> $stable(parked));
endmodule

bind ipi_dispatcher ipi_dispatcher_chk #(.MAX_CPUS(MAX_CPUS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_we        (cmd_we),
  .cmd_fire      (cmd_fire),
  .cmd_bad_reset (cmd_bad_reset),
  .int_post      (int_post),
  .cpu_reset     (cpu_reset),
  .cpu_halt      (cpu_halt),
  .cpu_resume    (cpu_resume),
  .err_bad_reset (err_bad_reset),
  .parked        (parked)
);

// File: tb/ipi_dispatcher_tb.sv
module ipi_dispatcher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [5:0]  cpu_count = 6'd32;
  logic [NCPU-1:0] int_post, cpu_reset, cpu_halt, cpu_resume, parked;
  logic [4:0]  out_cpu;
  logic [5:0]  out_vec;
  logic        err_bad_reset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [NCPU-1:0] m_parked = '0;
  logic [4:0]      m_cpu = '0;
  logic [5:0]      m_vec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dispatcher #(.MAX_CPUS(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cpu_count(cpu_count), .int_post(int_post), .cpu_reset(cpu_reset),
    .cpu_halt(cpu_halt), .cpu_resume(cpu_resume), .out_cpu(out_cpu),
    .out_vec(out_vec), .err_bad_reset(err_bad_reset), .parked(parked)
  );

  // Field layout (R2): type [17:16], target [12:8], vector [5:0]
  function automatic logic [31:0] mk(input logic [1:0] t, input logic [4:0] c,
                                     input logic [5:0] v, input logic [31:0] junk);
    logic [31:0] keep;
    keep = 32'h0003_1F3F;
    return (junk & ~keep) | {14'd0, t, 3'd0, c, 2'd0, v};
  endfunction

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    cmp(req, {32'd0, int_post | cpu_reset | cpu_halt | cpu_resume}, 64'd0);
    cmp(req, {63'd0, err_bad_reset}, 64'd0);
    cmp(req, {32'd0, parked}, {32'd0, m_parked});
  endtask

  task automatic send(input string req, input logic [31:0] w);
    logic [1:0] t;
    logic [4:0] c;
    logic [5:0] v;
    bit present, ok, bad;
    logic [NCPU-1:0] one, e_post, e_rst, e_halt, e_res;
    t = w[17:16]; c = w[12:8]; v = w[5:0];
    present = (int'(c) < int'(cpu_count)) && (int'(c) < NCPU);
    ok  = present && (t != 2'd1 || v == 6'h01);
    bad = present && t == 2'd1 && v != 6'h01;
    one = NCPU'(1) << c;
    e_post = (ok && t == 2'd0) ? one : '0;
    e_rst  = (ok && t == 2'd1) ? one : '0;
    e_halt = (ok && t == 2'd2) ? one : '0;
    e_res  = (ok && t == 2'd3) ? one : '0;
    if (ok) begin
      m_cpu = c;
      m_vec = (t == 2'd0) ? v : 6'd0;
      if (t == 2'd2) m_parked = m_parked | one;
      if (t == 2'd1 || t == 2'd3) m_parked = m_parked & ~one;
    end
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_we = 1'b0;
    cmp({req, " int_post"},   {32'd0, int_post},   {32'd0, e_post});
    cmp({req, " cpu_reset"},  {32'd0, cpu_reset},  {32'd0, e_rst});
    cmp({req, " cpu_halt"},   {32'd0, cpu_halt},   {32'd0, e_halt});
    cmp({req, " cpu_resume"}, {32'd0, cpu_resume}, {32'd0, e_res});
    cmp({req, " err"},        {63'd0, err_bad_reset}, {63'd0, bad});
    cmp({req, " out_cpu"},    {59'd0, out_cpu},    {59'd0, m_cpu});
    cmp({req, " out_vec"},    {58'd0, out_vec},    {58'd0, m_vec});
    cmp({req, " parked"},     {32'd0, parked},     {32'd0, m_parked});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1b2c_3d4e));
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1 strobes", {32'd0, int_post | cpu_reset | cpu_halt | cpu_resume}, 64'd0);
    cmp("R1 parked", {32'd0, parked}, 64'd0);
    cmp("R1 out", {52'd0, err_bad_reset, out_cpu, out_vec}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R11 idle after reset");

    // Directed corners
    cpu_count = 6'd32;
    send("R3 post top cpu", mk(2'd0, 5'd31, 6'h2a, 32'hFFFF_FFFF));
    send("R2 junk bits post", mk(2'd0, 5'd3, 6'h3f, 32'hA5A5_A5A5));
    send("R6 halt 31", mk(2'd2, 5'd31, 6'h00, 32'h0));
    send("R10 post to parked", mk(2'd0, 5'd31, 6'h11, 32'h0));
    send("R5 bad reset", mk(2'd1, 5'd31, 6'h02, 32'h0));
    cpu_count = 6'd31;
    send("R8 target equals count", mk(2'd3, 5'd31, 6'h00, 32'h0));
    send("R8 bad reset out of range", mk(2'd1, 5'd31, 6'h05, 32'h0));
    cpu_count = 6'd32;
    send("R7 resume 31", mk(2'd3, 5'd31, 6'h00, 32'h0));
    send("R6 halt 0", mk(2'd2, 5'd0, 6'h00, 32'h0));
    send("R4 por reset 0", mk(2'd1, 5'd0, 6'h01, 32'h0));
    cpu_count = 6'd1;
    send("R8 count one", mk(2'd0, 5'd1, 6'h07, 32'h0));
    send("R3 count one cpu0", mk(2'd0, 5'd0, 6'h07, 32'h0));
    cpu_count = 6'd0;
    send("R8 count zero", mk(2'd2, 5'd0, 6'h00, 32'h0));
    @(negedge clk);
    check_idle("R11 gap");

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      logic [1:0] t;
      logic [4:0] c;
      logic [5:0] v;
      int base;
      if (n % 40 == 0) cpu_count = 6'($urandom_range(1, 32));
      t = 2'($urandom_range(0, 3));
      base = (int'(cpu_count) > 3) ? int'(cpu_count) - 3 : 0;
      c = 5'($urandom_range(base, (base + 5 > 31) ? 31 : base + 5));
      v = ($urandom_range(0, 1) == 0) ? 6'h01 : 6'($urandom_range(0, 63));
      send("R3 R4 R5 R6 R7 R8 random", mk(t, c, v, $urandom()));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check_idle("R11 random gap");
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule